// File: doc/BRIEF.md
# Three-Rail Enable Sequencer

This controller drives the enable lines of three downstream power supplies from one enable request. When the request goes active, the three flags turn on one after another in ascending order. When the request goes inactive, they turn off in descending order. Every delay is counted in ticks of a slow timebase. The timebase arrives as a one-cycle tick-enable pulse on the system clock.

The enable request is synchronized before the state machine uses it.

- **Short glitch:** a glitch on the request that ends before the first flag asserts leaves every flag untouched.
- **Drop during power-up:** the controller unwinds from the highest flag already asserted.
- **Return during power-down:** the controller climbs again from the highest flag still asserted.

A polarity input selects whether an asserted flag reads as 1 or as 0. A status output and a set of raw, polarity-free flag bits expose the sequence for checking.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: While reset is high, and whenever the status is idle-off, all raw flags are 0 and every flag output is at its inactive level.
- R2: After the synchronized enable goes active from idle-off, flag 0 asserts on the 10th tick counted. That is a partial period up to the next tick followed by 9 full periods. Ticks that arrive while the request is still in the synchronizer do not count.
- R3: During power-up, flag 1 asserts exactly 8 ticks after flag 0, and flag 2 asserts exactly 8 ticks after flag 1.
- R4: After the enable goes inactive from all-on, flag 2 drops on the 10th counted tick. Flag 1 then drops 8 ticks later, and flag 0 drops 8 ticks after flag 1.
- R5: If the enable goes inactive before flag 0 asserts, the controller returns to idle-off with no flag change. A later power-up again needs the full first-step delay of R2.
- R6: If the enable goes inactive after flag 0 but before flag 2 asserts, the pending step is dropped. The highest asserted flag falls on the 10th counted tick, and each lower flag falls 8 ticks after the previous one.
- R7: If the enable goes active during power-down, no more flags drop. If all three flags are still on, the status returns to all-on. Otherwise the next flag up asserts on the 10th counted tick, followed by 8-tick steps.
- R8: With the polarity input at 0, a flag output equals its raw bit. With the polarity input at 1, it is the raw bit inverted.
- R9: The status output encodes idle-off as 2'b00, ramping up as 2'b01, all-on as 2'b10 and ramping down as 2'b11. Raw flag bit i is flag i, with flag 0 asserting first.
- R10: Ticks have no effect while the status is idle-off or all-on.
- R11: The enable passes through two synchronizer flops. A change applied before clock edge k shows on the status after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en_req | input | 1 | Asynchronous sequence enable request |
| tick | input | 1 | One-cycle timebase tick enable |
| inv_pol | input | 1 | 1 makes flag outputs active low |
| flag_out | output | 3 | Flag outputs after the polarity selection |
| flag_raw | output | 3 | Asserted state of each flag, before polarity |
| seq_status | output | 2 | Sequence status code |

## Verification
The bench builds the block with its default parameters: three rails, a first step of 9 full periods and later steps of 8, and two synchronizer stages. These values keep every step boundary within a few dozen ticks. The stimulus can therefore stop one tick short of each edge and one tick past it, and can cut a ramp short at every level in both directions. Ticks are spaced several clocks apart, so a tick that lands inside the synchronizer window can be separated from one the state machine counts.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_UP   = 2'b01,
        ST_ON   = 2'b10,
        ST_DN   = 2'b11
    } seq_state_e;

    // Ramp states are the only ones in which the tick counter runs.
    function automatic logic is_ramping(input seq_state_e s);
        return (s == ST_UP) || (s == ST_DN);
    endfunction

endpackage

// File: rtl/pwr_seq_sync.sv
module pwr_seq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain_q[g] <= 1'b0;
                else if (g == 0) chain_q[g] <= d_in;
                else chain_q[g] <= chain_q[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign d_out = chain_q[STAGES-1];
endmodule

// File: rtl/pwr_seq_delay.sv
module pwr_seq_delay #(
    parameter int FIRST_TICKS = 9,
    parameter int STEP_TICKS  = 8,
    localparam int FIRST_TGT  = FIRST_TICKS + 1,
    localparam int MAX_TGT    = (FIRST_TGT > STEP_TICKS) ? FIRST_TGT : STEP_TICKS,
    localparam int CNT_W      = $clog2(MAX_TGT + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    input  logic first,
    input  logic tick,
    output logic step_done
);
    localparam logic [CNT_W-1:0] FIRST_LAST = CNT_W'(FIRST_TGT - 1);
    localparam logic [CNT_W-1:0] STEP_LAST  = CNT_W'(STEP_TICKS - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_val;

    assign last_val  = first ? FIRST_LAST : STEP_LAST;
    assign step_done = run && !clear && tick && (cnt_q == last_val);

    always_ff @(posedge clk) begin
        if (rst || clear || step_done) cnt_q <= '0;
        else if (run && tick)          cnt_q <= cnt_q + 1'b1;
    end

    // R2/R3: the counter never passes the longest step length.
    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q < CNT_W'(MAX_TGT));

    // R10: when not running, ticks leave the count unchanged.
    a_r10_cnt_quiet: assert property (@(posedge clk) disable iff (rst)
        (!run && !clear) |=> $stable(cnt_q));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NUM_RAILS   = 3,
    parameter int FIRST_TICKS = 9,
    parameter int STEP_TICKS  = 8,
    parameter int SYNC_STAGES = 2,
    localparam int LVL_W      = $clog2(NUM_RAILS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en_req,
    input  logic                 tick,
    input  logic                 inv_pol,
    output logic [NUM_RAILS-1:0] flag_out,
    output logic [NUM_RAILS-1:0] flag_raw,
    output logic [1:0]           seq_status
);
    localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(NUM_RAILS);

    seq_state_e       state_q, state_d;
    logic [LVL_W-1:0] level_q, level_d;
    logic             first_q, first_d;
    logic             clear;
    logic             en_s;
    logic             step_done;

    pwr_seq_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst   (rst),
        .d_in  (en_req),
        .d_out (en_s)
    );

    pwr_seq_delay #(.FIRST_TICKS(FIRST_TICKS), .STEP_TICKS(STEP_TICKS)) delay_i (
        .clk       (clk),
        .rst       (rst),
        .clear     (clear),
        .run       (is_ramping(state_q)),
        .first     (first_q),
        .tick      (tick),
        .step_done (step_done)
    );

    always_comb begin
        state_d = state_q;
        level_d = level_q;
        first_d = first_q;
        clear   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (en_s) begin
                state_d = ST_UP;
                first_d = 1'b1;
                clear   = 1'b1;
            end
            ST_UP: begin
                if (!en_s) begin
                    clear   = 1'b1;
                    first_d = 1'b1;
                    state_d = (level_q == '0) ? ST_IDLE : ST_DN;
                end else if (step_done) begin
                    level_d = level_q + 1'b1;
                    first_d = 1'b0;
                    if (level_d == LVL_FULL) state_d = ST_ON;
                end
            end
            ST_ON: if (!en_s) begin
                state_d = ST_DN;
                first_d = 1'b1;
                clear   = 1'b1;
            end
            ST_DN: begin
                if (en_s) begin
                    clear   = 1'b1;
                    first_d = 1'b1;
                    state_d = (level_q == LVL_FULL) ? ST_ON : ST_UP;
                end else if (step_done) begin
                    level_d = level_q - 1'b1;
                    first_d = 1'b0;
                    if (level_d == '0) state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            level_q <= '0;
            first_q <= 1'b1;
        end else begin
            state_q <= state_d;
            level_q <= level_d;
            first_q <= first_d;
        end
    end

    generate
        for (genvar i = 0; i < NUM_RAILS; i++) begin : g_flag
            assign flag_raw[i] = (level_q > LVL_W'(i));
            assign flag_out[i] = flag_raw[i] ^ inv_pol;
        end
    endgenerate

    assign seq_status = state_q;

    // R1: idle-off never shows an asserted flag.
    a_r1_idle_no_flags: assert property (@(posedge clk) disable iff (rst)
        (seq_status == 2'b00) |-> (flag_raw == '0));

    // R2/R4: flags always form a contiguous run from flag 0 upward.
    a_r2_thermometer: assert property (@(posedge clk) disable iff (rst)
        ((flag_raw + 1'b1) & flag_raw) == '0);

    // R3/R6: at most one flag changes per clock.
    a_r6_one_step: assert property (@(posedge clk) disable iff (rst)
        $countones(flag_raw ^ $past(flag_raw)) <= 1);

    // R9: all-on status implies every flag asserted.
    a_r9_allon_full: assert property (@(posedge clk) disable iff (rst)
        (seq_status == 2'b10) |-> (&flag_raw));

    // R5: a drop before the first flag goes straight back to idle-off.
    a_r5_glitch_idle: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_UP && level_q == '0 && !en_s) |=>
            (seq_status == 2'b00 && flag_raw == '0));

    // R10: no flag moves while idle-off or all-on.
    a_r10_hold_flags: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE || state_q == ST_ON) |=> $stable(flag_raw));
endmodule

// File: tb/pwr_seq_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_seq_ctrl_tb_top;

    typedef struct packed {
        logic       en;
        logic [5:0] ticks;
        logic [2:0] raw;
        logic [1:0] st;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 6'd9,  3'b000, 2'b01, 4'd2},   // R2 one tick short
        '{1'b1, 6'd1,  3'b001, 2'b01, 4'd2},   // R2 flag 0 on 10th tick
        '{1'b1, 6'd7,  3'b001, 2'b01, 4'd3},   // R3 one short
        '{1'b1, 6'd1,  3'b011, 2'b01, 4'd3},   // R3 flag 1 at 8
        '{1'b1, 6'd8,  3'b111, 2'b10, 4'd3},   // R3 flag 2 at 8
        '{1'b1, 6'd20, 3'b111, 2'b10, 4'd10},  // R10 all-on ignores ticks
        '{1'b0, 6'd9,  3'b111, 2'b11, 4'd4},   // R4 one short
        '{1'b0, 6'd1,  3'b011, 2'b11, 4'd4},   // R4 flag 2 drops
        '{1'b0, 6'd8,  3'b001, 2'b11, 4'd4},   // R4 flag 1 drops
        '{1'b0, 6'd8,  3'b000, 2'b00, 4'd4},   // R4 flag 0 drops
        '{1'b0, 6'd5,  3'b000, 2'b00, 4'd10},  // R10 idle ignores ticks
        '{1'b1, 6'd6,  3'b000, 2'b01, 4'd5},   // R5 partial count
        '{1'b0, 6'd0,  3'b000, 2'b00, 4'd5},   // R5 glitch back to idle
        '{1'b1, 6'd9,  3'b000, 2'b01, 4'd5},   // R5 full delay again
        '{1'b1, 6'd1,  3'b001, 2'b01, 4'd5},   // R5 flag 0 after reset count
        '{1'b0, 6'd9,  3'b001, 2'b11, 4'd6},   // R6 drop at level 1
        '{1'b0, 6'd1,  3'b000, 2'b00, 4'd6},   // R6 flag 0 on 10th
        '{1'b1, 6'd10, 3'b001, 2'b01, 4'd2},   // R2 restart
        '{1'b1, 6'd8,  3'b011, 2'b01, 4'd3},   // R3
        '{1'b0, 6'd10, 3'b001, 2'b11, 4'd6},   // R6 highest flag drops
        '{1'b1, 6'd9,  3'b001, 2'b01, 4'd7},   // R7 resume, one short
        '{1'b1, 6'd1,  3'b011, 2'b01, 4'd7},   // R7 next flag on 10th
        '{1'b1, 6'd8,  3'b111, 2'b10, 4'd7},   // R7 then 8-tick step
        '{1'b0, 6'd10, 3'b011, 2'b11, 4'd4},   // R4
        '{1'b1, 6'd0,  3'b011, 2'b01, 4'd7},   // R7 drops stop
        '{1'b1, 6'd10, 3'b111, 2'b10, 4'd7},   // R7
        '{1'b0, 6'd9,  3'b111, 2'b11, 4'd7},   // R7 before first drop
        '{1'b1, 6'd0,  3'b111, 2'b10, 4'd7},   // R7 back to all-on
        '{1'b0, 6'd26, 3'b000, 2'b00, 4'd4}    // R4 full unwind
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en_req = 1'b0;
    logic       tick = 1'b0;
    logic       inv_pol = 1'b0;
    logic [2:0] flag_out;
    logic [2:0] flag_raw;
    logic [1:0] seq_status;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pwr_seq_ctrl dut_i (
        .clk        (clk),
        .rst        (rst),
        .en_req     (en_req),
        .tick       (tick),
        .inv_pol    (inv_pol),
        .flag_out   (flag_out),
        .flag_raw   (flag_raw),
        .seq_status (seq_status)
    );

    task automatic ticks_n(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    task automatic chk(input string req, input logic [2:0] r, input logic [1:0] s,
                       input logic [2:0] fo);
        n_chk++;
        if (flag_raw !== r || seq_status !== s || flag_out !== fo) begin
            n_bad++;
            $display("FAIL %s: raw=%b st=%b out=%b expected raw=%b st=%b out=%b",
                     req, flag_raw, seq_status, flag_out, r, s, fo);
        end
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset", 3'b000, 2'b00, 3'b000);
        inv_pol = 1'b1;
        #1 chk("R1 reset inactive high", 3'b000, 2'b00, 3'b111);
        inv_pol = 1'b0;
        @(negedge clk) rst = 1'b0;

        // R11: status moves after the third edge; tick in the window is not counted (R2)
        en_req = 1'b1;
        tick   = 1'b1;
        @(negedge clk) tick = 1'b0;
        @(negedge clk);
        chk("R11 still idle after two edges", 3'b000, 2'b00, 3'b000);
        @(negedge clk);
        chk("R11 up after third edge", 3'b000, 2'b01, 3'b000);
        ticks_n(9);
        chk("R2 window tick ignored", 3'b000, 2'b01, 3'b000);
        ticks_n(1);
        chk("R2 flag 0", 3'b001, 2'b01, 3'b001);
        ticks_n(8);
        // reset mid-sequence returns to idle (R1)
        @(negedge clk) rst = 1'b1;
        en_req = 1'b0;
        repeat (4) @(negedge clk);
        chk("R1 reset mid sequence", 3'b000, 2'b00, 3'b000);
        @(negedge clk) rst = 1'b0;
        repeat (3) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk) en_req = VEC[v].en;
            repeat (5) @(negedge clk);
            ticks_n(int'(VEC[v].ticks));
            @(negedge clk);
            chk($sformatf("R%0d vector %0d", VEC[v].req, v),
                VEC[v].raw, VEC[v].st, VEC[v].raw);
        end

        // R8 polarity in idle and in all-on
        inv_pol = 1'b1;
        @(negedge clk);
        chk("R8 idle inverted", 3'b000, 2'b00, 3'b111);
        en_req = 1'b1;
        repeat (5) @(negedge clk);
        ticks_n(26);
        chk("R8 all-on inverted", 3'b111, 2'b10, 3'b000);
        inv_pol = 1'b0;
        @(negedge clk);
        chk("R8 all-on true", 3'b111, 2'b10, 3'b111);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule